// File: doc/BRIEF.md
# Receive Flush and Wake Controller

This block decides when bytes waiting in a device's receive buffer are handed over to the USB IN endpoint. It watches the buffer fill level and raises a one-cycle send request carrying a packet length. A request is raised in three cases: a full packet is available, a programmable latency timer runs out while data is waiting, or the active-low send-now/wake pin is strobed.

The same pin has a second use. While the bus is suspended and remote wakeup is enabled, a low level on it raises a single resume request toward the host. The buffer storage and the USB signalling are outside the block. The consumer is expected to remove the requested bytes from the fill level by the second clock edge after the request.

Top module: `rxfw_ctrl`

## Requirements
- R1: After reset, `send_req` and `resume_req` are low, and `send_len` reads 0 whenever `send_req` is low.
- R2: When not suspended and no request was issued in the previous cycle, a fill level of at least PKT_MAX (64) raises `send_req` in the next cycle with `send_len` = 64.
- R3: `send_req` is never high in two consecutive cycles.
- R4: The latency counter adds one per `tick_1ms` only while the fill level is nonzero and the bus is not suspended. It clears when the buffer is empty and after every request. In the cycle after the counter reaches `lat_ms`, a request with length min(fill, 64) is raised. A `lat_ms` value of 0 acts as 1.
- R5: `siwu_n` passes through two synchroniser flops. A falling edge raises one request with length min(fill, 64) on the third clock edge after the pin goes low. Holding the pin low raises no further requests.
- R6: After a strobe, requests continue until one shorter than 64 bytes has been issued. If a strobe finds the buffer empty, a zero-length request (`send_len` = 0) is issued.
- R7: When a timer expiry and a strobe edge reach the decision in the same cycle, exactly one request is issued and the latency counter restarts from zero.
- R8: While `bus_suspended` is high, no send request is issued. A pin strobe seen during suspend is discarded and has no effect after suspend ends. A full buffer is released only after suspend ends.
- R9: While suspended with `rwake_en` high, a synchronised low pin level raises `resume_req` for exactly one cycle, three edges after the pin falls. It is not raised again until `bus_suspended` has gone low.
- R10: With `rwake_en` low, `resume_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_lvl | input | FILL_W (9) | Bytes waiting in the receive buffer |
| tick_1ms | input | 1 | One-cycle millisecond tick |
| lat_ms | input | LAT_W (8) | Latency timer setting in ms |
| bus_suspended | input | 1 | Bus is in suspend |
| rwake_en | input | 1 | Remote wakeup allowed |
| siwu_n | input | 1 | Asynchronous send-now / wake pin, active low |
| send_req | output | 1 | One-cycle packet release request |
| send_len | output | LEN_W (7) | Length of the released packet |
| resume_req | output | 1 | One-cycle resume request |

## Verification
A timer expiry and a pin strobe can reach the request decision in the same cycle. The bench provokes this by sending two millisecond ticks during the same two cycles in which the pin falls through the synchroniser, so both reach the third edge together. The result is judged correct only if exactly one request appears with the pending length. The restart is judged by what follows: the next request must need a full two further ticks, because a counter that was not cleared would fire again two edges later.

// File: rtl/rxfw_pkg.sv
package rxfw_pkg;
   // reason a release was decided, used for internal steering
   typedef struct packed {
      logic full;
      logic flush;
      logic expire;
   } rxfw_cause_t;

   function automatic logic any_cause(input rxfw_cause_t c);
      return c.full | c.flush | c.expire;
   endfunction
endpackage

// File: rtl/rxfw_pin_sync.sv
module rxfw_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic lvl_low,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxfw_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '1;
         prev <= 1'b1;
      end else begin
         sr   <= {sr[STAGES-2:0], pin_n};
         prev <= sr[STAGES-1];
      end
   end

   assign lvl_low = ~sr[STAGES-1];
   assign fall    = prev & ~sr[STAGES-1];
endmodule

// File: rtl/rxfw_lat_timer.sv
module rxfw_lat_timer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [LAT_W-1:0] lat_set,
   input  logic             pending,
   input  logic             hold,
   input  logic             restart,
   output logic             expired
);
   if (LAT_W < 1) begin : g_bad_width
      $error("rxfw_lat_timer: LAT_W must be positive");
   end

   localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

   logic [LAT_W-1:0] cnt;
   logic [LAT_W-1:0] lat_eff;

   assign lat_eff = (lat_set == '0) ? ONE : lat_set;
   assign expired = pending & ~hold & (cnt >= lat_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || !pending || hold) begin
         cnt <= '0;
      end else if (tick && cnt != '1) begin
         cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/rxfw_flush_arb.sv
module rxfw_flush_arb
   import rxfw_pkg::*;
#(
   parameter int FILL_W       = 9,
   parameter int LEN_W        = 7,
   parameter int PKT_MAX      = 64,
   parameter bit ZLP_ON_EMPTY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] fill,
   input  logic              suspended,
   input  logic              strobe,
   input  logic              expired,
   output logic              restart,
   output logic              req,
   output logic [LEN_W-1:0]  len
);
   localparam logic [FILL_W-1:0] PKT_F = FILL_W'(PKT_MAX);
   localparam logic [LEN_W-1:0]  PKT_L = LEN_W'(PKT_MAX);

   logic            armed;
   logic            arm_now;
   logic            nonempty;
   logic            flush_ok;
   rxfw_cause_t     cause;
   logic            want;
   logic [LEN_W-1:0] len_c;

   assign nonempty = (fill != '0);
   assign arm_now  = armed | strobe;

   if (ZLP_ON_EMPTY) begin : g_zlp
      assign flush_ok = arm_now;
   end else begin : g_no_zlp
      assign flush_ok = arm_now & nonempty;
   end

   assign cause.full   = (fill >= PKT_F);
   assign cause.flush  = flush_ok;
   assign cause.expire = expired;

   assign want    = ~suspended & ~req & any_cause(cause);
   assign len_c   = cause.full ? PKT_L : fill[LEN_W-1:0];
   assign restart = want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req   <= 1'b0;
         len   <= '0;
         armed <= 1'b0;
      end else begin
         req <= want;
         len <= want ? len_c : '0;
         if (suspended)
            armed <= 1'b0;
         else if (want)
            armed <= arm_now & (len_c == PKT_L);
         else if (!ZLP_ON_EMPTY && !nonempty)
            armed <= 1'b0;
         else if (strobe)
            armed <= 1'b1;
      end
   end
endmodule

// File: rtl/rxfw_wake.sv
module rxfw_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic suspended,
   input  logic wake_en,
   input  logic pin_low,
   output logic resume
);
   logic done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resume <= 1'b0;
         done   <= 1'b0;
      end else begin
         resume <= 1'b0;
         if (!suspended) begin
            done <= 1'b0;
         end else if (wake_en && pin_low && !done) begin
            resume <= 1'b1;
            done   <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxfw_ctrl.sv
module rxfw_ctrl #(
   parameter int  BUF_DEPTH    = 384,
   parameter int  PKT_MAX      = 64,
   parameter int  LAT_W        = 8,
   parameter int  SYNC_STAGES  = 2,
   parameter bit  ZLP_ON_EMPTY = 1'b1,
   localparam int FILL_W       = $clog2(BUF_DEPTH + 1),
   localparam int LEN_W        = $clog2(PKT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] fill_lvl,
   input  logic              tick_1ms,
   input  logic [LAT_W-1:0]  lat_ms,
   input  logic              bus_suspended,
   input  logic              rwake_en,
   input  logic              siwu_n,
   output logic              send_req,
   output logic [LEN_W-1:0]  send_len,
   output logic              resume_req
);
   if (PKT_MAX < 1 || PKT_MAX > BUF_DEPTH) begin : g_bad_pkt
      $error("rxfw_ctrl: PKT_MAX must lie in 1..BUF_DEPTH");
   end

   logic pin_low;
   logic pin_fall;
   logic tmr_exp;
   logic tmr_restart;

   rxfw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (siwu_n),
      .lvl_low (pin_low),
      .fall    (pin_fall)
   );

   rxfw_lat_timer #(.LAT_W(LAT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1ms),
      .lat_set (lat_ms),
      .pending (fill_lvl != '0),
      .hold    (bus_suspended),
      .restart (tmr_restart),
      .expired (tmr_exp)
   );

   rxfw_flush_arb #(
      .FILL_W       (FILL_W),
      .LEN_W        (LEN_W),
      .PKT_MAX      (PKT_MAX),
      .ZLP_ON_EMPTY (ZLP_ON_EMPTY)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill      (fill_lvl),
      .suspended (bus_suspended),
      .strobe    (pin_fall),
      .expired   (tmr_exp),
      .restart   (tmr_restart),
      .req       (send_req),
      .len       (send_len)
   );

   rxfw_wake u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .suspended (bus_suspended),
      .wake_en   (rwake_en),
      .pin_low   (pin_low),
      .resume    (resume_req)
   );
endmodule

// File: rtl/rxfw_ctrl_chk.sv
module rxfw_ctrl_chk #(
   parameter int FILL_W  = 9,
   parameter int LEN_W   = 7,
   parameter int PKT_MAX = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FILL_W-1:0] fill_lvl,
   input logic              bus_suspended,
   input logic              rwake_en,
   input logic              send_req,
   input logic [LEN_W-1:0]  send_len,
   input logic              resume_req
);
   localparam logic [FILL_W-1:0] PKT_F = FILL_W'(PKT_MAX);
   localparam logic [LEN_W-1:0]  PKT_L = LEN_W'(PKT_MAX);

   AST_IDLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      !send_req |-> send_len == '0); // R1
   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      send_req |-> send_len <= PKT_L); // R2
   AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_suspended && !send_req && fill_lvl >= PKT_F) |=> (send_req && send_len == PKT_L)); // R2
   AST_REQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      send_req |=> !send_req); // R3
   AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_suspended |=> !send_req); // R8
   AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resume_req |=> !resume_req); // R9
   AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      resume_req |-> $past(bus_suspended && rwake_en)); // R10
endmodule

bind rxfw_ctrl rxfw_ctrl_chk #(
   .FILL_W  (FILL_W),
   .LEN_W   (LEN_W),
   .PKT_MAX (PKT_MAX)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fill_lvl      (fill_lvl),
   .bus_suspended (bus_suspended),
   .rwake_en      (rwake_en),
   .send_req      (send_req),
   .send_len      (send_len),
   .resume_req    (resume_req)
);

// File: tb/tb_rxfw_ctrl.sv
module tb_rxfw_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] fill_lvl = '0;
   logic       tick_1ms = 1'b0;
   logic [7:0] lat_ms = 8'd255;
   logic       bus_suspended = 1'b0;
   logic       rwake_en = 1'b0;
   logic       siwu_n = 1'b1;
   logic       send_req;
   logic [6:0] send_len;
   logic       resume_req;

   int  n_run = 0;
   int  n_fail = 0;
   bit  drain = 1'b0;
   bit  logging = 1'b0;
   int  nlog = 0;
   int  lens [0:15];

   always #5 clk = ~clk;

   rxfw_ctrl dut (
      .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .tick_1ms(tick_1ms),
      .lat_ms(lat_ms), .bus_suspended(bus_suspended), .rwake_en(rwake_en),
      .siwu_n(siwu_n), .send_req(send_req), .send_len(send_len),
      .resume_req(resume_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_req(input string tag, input bit er, input int el);
      chk(tag, int'(send_req), int'(er));
      if (er && send_req) chk(tag, int'(send_len), el);
   endtask

   task automatic step();
      @(negedge clk);
      if (send_req) begin
         if (logging && nlog < 16) begin
            lens[nlog] = int'(send_len);
            nlog++;
         end
         if (drain) fill_lvl = fill_lvl - 9'(send_len);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", 100000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      step();
      chk("R1 send_req", int'(send_req), 0);
      chk("R1 send_len", int'(send_len), 0);
      chk("R1 resume_req", int'(resume_req), 0);

      // R2/R3: sweep of fill levels with the level held constant
      for (int f = 0; f <= 130; f++) begin
         fill_lvl = 9'(f);
         step(); chk_req("R2 full release", f >= 64, 64);
         step(); chk_req("R3 spacing", 1'b0, 0);
         step(); chk_req("R2 repeat", f >= 64, 64);
         fill_lvl = '0;
         idle(2);
      end
      fill_lvl = 9'd384;
      step(); chk_req("R2 max fill", 1'b1, 64);
      fill_lvl = '0;
      idle(2);

      // R4: latency sweep, setting 0 behaves as 1
      foreach (lens[i]) lens[i] = 0;
      for (int s = 0; s < 5; s++) begin
         int lat;
         int le;
         lat = (s == 4) ? 7 : s;
         le  = (lat == 0) ? 1 : lat;
         lat_ms = 8'(lat);
         fill_lvl = 9'd10;
         for (int k = 1; k <= le; k++) begin
            tick_1ms = 1'b1;
            step();
            tick_1ms = 1'b0;
            chk_req("R4 before expiry", 1'b0, 0);
            step();
            chk_req("R4 expiry", k == le, 10);
         end
         fill_lvl = '0;
         idle(2);
      end

      // R4: no counting while empty
      lat_ms = 8'd2;
      for (int k = 0; k < 3; k++) begin
         tick_1ms = 1'b1; step(); tick_1ms = 1'b0; step();
      end
      fill_lvl = 9'd5;
      step(); chk_req("R4 empty hold", 1'b0, 0);
      step(); chk_req("R4 empty hold", 1'b0, 0);
      tick_1ms = 1'b1; step(); tick_1ms = 1'b0;
      step(); chk_req("R4 one tick", 1'b0, 0);
      tick_1ms = 1'b1; step(); tick_1ms = 1'b0;
      chk_req("R4 second tick", 1'b0, 0);
      step(); chk_req("R4 second tick", 1'b1, 5);
      fill_lvl = '0;
      idle(2);

      // R5: strobe with short data, single request per strobe
      lat_ms = 8'd255;
      drain = 1'b1;
      fill_lvl = 9'd20;
      siwu_n = 1'b0;
      step(); chk_req("R5 sync", 1'b0, 0);
      step(); chk_req("R5 sync", 1'b0, 0);
      step(); chk_req("R5 strobe", 1'b1, 20);
      for (int i = 0; i < 6; i++) begin
         step(); chk_req("R5 held low", 1'b0, 0);
      end
      chk("R5 drained", int'(fill_lvl), 0);
      siwu_n = 1'b1;
      idle(3);

      // R6: strobe on empty buffer gives a zero-length request
      siwu_n = 1'b0;
      step(); step();
      step(); chk_req("R6 zero length", 1'b1, 0);
      siwu_n = 1'b1;
      idle(4);

      // R6: 128 bytes without strobe: two packets only
      logging = 1'b1; nlog = 0;
      fill_lvl = 9'd128;
      idle(12);
      chk("R6 plain count", nlog, 2);
      chk("R6 plain len", lens[1], 64);
      // R6: 128 bytes with strobe: two full packets then zero length
      nlog = 0;
      fill_lvl = 9'd128;
      siwu_n = 1'b0;
      idle(12);
      chk("R6 flush count", nlog, 3);
      chk("R6 flush len0", lens[0], 64);
      chk("R6 flush len1", lens[1], 64);
      chk("R6 flush len2", lens[2], 0);
      logging = 1'b0;
      siwu_n = 1'b1;
      drain = 1'b0;
      idle(4);

      // R7: expiry and strobe decided at the same edge
      lat_ms = 8'd2;
      fill_lvl = 9'd10;
      siwu_n = 1'b0;
      tick_1ms = 1'b1;
      step();
      step();
      tick_1ms = 1'b0;
      chk_req("R7 pre", 1'b0, 0);
      step(); chk_req("R7 single", 1'b1, 10);
      step(); chk_req("R7 single", 1'b0, 0);
      tick_1ms = 1'b1; step(); tick_1ms = 1'b0;
      chk_req("R7 restart", 1'b0, 0);
      step(); chk_req("R7 restart", 1'b0, 0);
      tick_1ms = 1'b1; step(); tick_1ms = 1'b0;
      chk_req("R7 restart", 1'b0, 0);
      step(); chk_req("R7 full count", 1'b1, 10);
      siwu_n = 1'b1;
      fill_lvl = '0;
      idle(3);

      // R8/R9/R10: suspend behaviour
      bus_suspended = 1'b1;
      rwake_en = 1'b0;
      lat_ms = 8'd1;
      fill_lvl = 9'd20;
      siwu_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
         tick_1ms = 1'b1;
         step();
         chk("R10 no resume", int'(resume_req), 0);
         chk_req("R8 no send", 1'b0, 0);
      end
      tick_1ms = 1'b0;
      siwu_n = 1'b1;
      idle(3);
      rwake_en = 1'b1;
      siwu_n = 1'b0;
      step(); chk("R9 sync", int'(resume_req), 0);
      step(); chk("R9 sync", int'(resume_req), 0);
      step(); chk("R9 resume", int'(resume_req), 1);
      for (int i = 0; i < 4; i++) begin
         step(); chk("R9 single pulse", int'(resume_req), 0);
      end
      siwu_n = 1'b1;
      idle(3);
      siwu_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
         step(); chk("R9 no repeat", int'(resume_req), 0);
      end
      siwu_n = 1'b1;
      fill_lvl = 9'd100;
      for (int i = 0; i < 3; i++) begin
         step(); chk_req("R8 full held", 1'b0, 0);
      end
      fill_lvl = 9'd20;
      lat_ms = 8'd255;
      step();
      bus_suspended = 1'b0;
      for (int i = 0; i < 5; i++) begin
         step(); chk_req("R8 strobe discarded", 1'b0, 0);
      end
      fill_lvl = 9'd100;
      step(); chk_req("R8 release after suspend", 1'b1, 64);
      fill_lvl = '0;
      idle(3);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule